// File: doc/BRIEF.md
# Clock Page Replacement Victim Selector

This block keeps a small status record for every physical frame of a paged memory and answers one question on demand: which frame should receive the next page. Frames below a fixed base frame (192 by default) belong to the system and are never handed out. The usable range runs from the base frame up to a runtime limit, and that limit may be set anywhere from 194 to 1024 frames. While the range still holds frames that were never given out, a request gets the next such frame and nothing is evicted. Once the range is full, a clock hand steps around it one frame per cycle. A frame that has been referenced gets a second chance. A frame that software has pinned is passed over.

Software drives an update port to set or clear the referenced, dirty and pinned flags of any frame. A request is a single-cycle pulse. The answer is either a single-cycle grant that carries the frame number, or a no-victim pulse. When the chosen frame is dirty, the block raises a write-back request for that frame and holds it until an acknowledge arrives; only then does it grant the frame. A mode input chosen per request selects a two-class sweep. This sweep first looks for a frame that is both unreferenced and clean, and falls back to one that is unreferenced and dirty.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset or a synchronous `init` pulse, `busy`, `gnt`, `wb_req` and `no_victim` are low and all flags are clear. Both the fill pointer and the hand point at frame 192. Every granted frame lies in 192 to `lim`-1.
- R2: While unissued frames remain, requests are granted in ascending order from 192 with no write-back. A frame pinned while still unissued is passed over and never granted.
- R3: A frame whose pinned flag is set is never chosen as a victim.
- R4: Simple mode (`enh`=0): at the hand, a referenced frame has its referenced flag cleared and the hand moves on. The first unreferenced, unpinned frame is the victim.
- R5: A dirty victim raises `wb_req` with `wb_frame` equal to the victim, and both stay steady until `wb_ack`. `gnt` follows on the cycle after the acknowledge, and never while `wb_req` is high.
- R6: Two-class mode (`enh`=1): even sweeps take the first frame that is unreferenced and clean, and change no flag. Odd sweeps take the first unreferenced frame and clear the referenced flags they pass. The two kinds of sweep alternate.
- R7: After a victim is chosen the hand points at the next frame, and it wraps from `lim`-1 back to 192.
- R8: If no victim is found within 2 full sweeps (simple mode) or 4 full sweeps (two-class mode), `no_victim` pulses for one cycle without a grant and the block returns to idle.
- R9: When `upd_en` is high, each flag selected in `upd_mask` (bit 0 referenced, bit 1 dirty, bit 2 pinned) of frame `upd_frame` takes the value `upd_set`. A granted frame becomes referenced and clean.
- R10: `busy` is high from the cycle after an accepted request until the grant or no-victim pulse. `req` is sampled only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous clear of all state |
| lim | input | FW+1 | Number of frames; usable frames are 192..lim-1 |
| req | input | 1 | Victim request pulse |
| enh | input | 1 | Two-class sweep select for this request |
| upd_en | input | 1 | Flag update strobe |
| upd_frame | input | FW | Frame whose flags are updated |
| upd_set | input | 1 | Value written to the selected flags |
| upd_mask | input | 3 | Flag select: bit0 ref, bit1 dirty, bit2 pin |
| wb_ack | input | 1 | Write-back done |
| busy | output | 1 | Search in progress |
| gnt | output | 1 | Grant pulse |
| gnt_frame | output | FW | Granted frame |
| wb_req | output | 1 | Dirty victim awaiting write-back |
| wb_frame | output | FW | Frame to write back |
| no_victim | output | 1 | Search failed pulse |

## Verification
The assertions check on every cycle that grants stay inside the usable range and that the write-back request holds its frame steady until acknowledged. They also check that a grant never coincides with a pending write-back or a no-victim pulse, and that every grant ends a busy period. Which frame wins in each mode, where the hand moves, how referenced flags are cleared, and how the sweep gives up when every frame is pinned can only be shown by the bench's request sequences against a hand-worked flag state.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int FW    = 10,
  parameter int FIRST = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [FW:0]   lim,
  input  logic          req,
  input  logic          enh,
  input  logic          upd_en,
  input  logic [FW-1:0] upd_frame,
  input  logic          upd_set,
  input  logic [2:0]    upd_mask,
  input  logic          wb_ack,
  output logic          busy,
  output logic          gnt,
  output logic [FW-1:0] gnt_frame,
  output logic          wb_req,
  output logic [FW-1:0] wb_frame,
  output logic          no_victim
);
  localparam int NF = 1 << FW;
  typedef enum logic [1:0] {IDLE, FILL, SWEEP, WBACK} st_t;

  st_t st;
  logic [NF-1:0] refb, dirt, pin;
  logic [FW-1:0] hand, scnt;
  logic [FW:0]   fptr;
  logic [2:0]    sw;
  logic          enh_l;

  wire [FW:0]   span    = lim - FW'(FIRST);
  wire [FW:0]   hp1     = {1'b0, hand} + 1'b1;
  wire [FW-1:0] hand_nx = (hp1 == lim) ? FW'(FIRST) : hp1[FW-1:0];
  wire          pass0   = enh_l && !sw[0];
  wire          h_ref   = refb[hand];
  wire          h_dirt  = dirt[hand];
  wire          h_pin   = pin[hand];
  wire          take    = !h_pin && !h_ref && (!pass0 || !h_dirt);
  wire          clr     = !h_pin && h_ref && !pass0;
  wire [2:0]    maxsw   = enh_l ? 3'd4 : 3'd2;
  wire          last    = ({1'b0, scnt} == span - 1'b1);

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; refb <= '0; dirt <= '0; pin <= '0;
      hand <= FW'(FIRST); fptr <= (FW+1)'(FIRST); scnt <= '0; sw <= '0; enh_l <= 1'b0;
      gnt <= 1'b0; gnt_frame <= '0; wb_req <= 1'b0; wb_frame <= '0; no_victim <= 1'b0;
    end else if (init) begin
      st <= IDLE; refb <= '0; dirt <= '0; pin <= '0;
      hand <= FW'(FIRST); fptr <= (FW+1)'(FIRST); scnt <= '0; sw <= '0; enh_l <= 1'b0;
      gnt <= 1'b0; wb_req <= 1'b0; no_victim <= 1'b0;
    end else begin
      gnt <= 1'b0;
      no_victim <= 1'b0;
      case (st)
        IDLE: if (req) begin
          enh_l <= enh; scnt <= '0; sw <= '0;
          st <= (fptr < lim) ? FILL : SWEEP;
        end
        FILL: if (fptr >= lim) st <= SWEEP;
        else begin
          fptr <= fptr + 1'b1;
          if (!pin[fptr[FW-1:0]]) begin
            gnt <= 1'b1; gnt_frame <= fptr[FW-1:0];
            refb[fptr[FW-1:0]] <= 1'b1; dirt[fptr[FW-1:0]] <= 1'b0;
            st <= IDLE;
          end
        end
        SWEEP: if (take) begin
          hand <= hand_nx;
          if (h_dirt) begin
            wb_req <= 1'b1; wb_frame <= hand; st <= WBACK;
          end else begin
            gnt <= 1'b1; gnt_frame <= hand;
            refb[hand] <= 1'b1; st <= IDLE;
          end
        end else begin
          if (clr) refb[hand] <= 1'b0;
          hand <= hand_nx;
          if (last) begin
            scnt <= '0; sw <= sw + 1'b1;
            if (sw + 1'b1 == maxsw) begin
              no_victim <= 1'b1; st <= IDLE;
            end
          end else scnt <= scnt + 1'b1;
        end
        WBACK: if (wb_ack) begin
          wb_req <= 1'b0; gnt <= 1'b1; gnt_frame <= wb_frame;
          refb[wb_frame] <= 1'b1; dirt[wb_frame] <= 1'b0; st <= IDLE;
        end
        default: st <= IDLE;
      endcase
      if (upd_en) begin
        if (upd_mask[0]) refb[upd_frame] <= upd_set;
        if (upd_mask[1]) dirt[upd_frame] <= upd_set;
        if (upd_mask[2]) pin[upd_frame]  <= upd_set;
      end
    end
  end
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int FW    = 10,
  parameter int FIRST = 192
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init,
  input logic [FW:0]   lim,
  input logic          busy,
  input logic          gnt,
  input logic [FW-1:0] gnt_frame,
  input logic          wb_req,
  input logic [FW-1:0] wb_frame,
  input logic          wb_ack,
  input logic          no_victim
);
  // R1
  grant_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> ({1'b0, gnt_frame} >= (FW+1)'(FIRST) && {1'b0, gnt_frame} < lim));
  // R5
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || init)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_frame)));
  // R5
  wb_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !gnt);
  // R8
  fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt, no_victim}));
  // R10
  gnt_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt || no_victim) |-> ($past(busy) && !busy));
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.FW(FW), .FIRST(FIRST)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .lim(lim), .busy(busy), .gnt(gnt),
  .gnt_frame(gnt_frame), .wb_req(wb_req), .wb_frame(wb_frame), .wb_ack(wb_ack),
  .no_victim(no_victim));

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;
  localparam int FW = 10;
  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0, req = 1'b0, enh = 1'b0;
  logic upd_en = 1'b0, upd_set = 1'b0, wb_ack = 1'b0;
  logic [FW:0] lim = 11'd200;
  logic [FW-1:0] upd_frame = '0;
  logic [2:0] upd_mask = '0;
  logic busy, gnt, wb_req, no_victim;
  logic [FW-1:0] gnt_frame, wb_frame;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  clock_victim_sel #(.FW(FW)) dut (.*);

  // {kind(1=req), enh, set, mask[2:0], frame[9:0], wb_exp, exp[9:0]}
  localparam int NV = 24;
  localparam logic [27:0] VEC [NV] = '{
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd192},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd193},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd194},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd195},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd196},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd197},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd198},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd199},
    {2'd0,1'b0,1'b1,3'b100,10'd192,1'b0,10'd0},
    {2'd0,1'b0,1'b0,3'b001,10'd195,1'b0,10'd0},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd195},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd193},
    {2'd0,1'b0,1'b1,3'b010,10'd194,1'b0,10'd0},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b1,10'd194},
    {2'd0,1'b0,1'b1,3'b010,10'd196,1'b0,10'd0},
    {2'd0,1'b0,1'b1,3'b010,10'd197,1'b0,10'd0},
    {2'd0,1'b0,1'b1,3'b010,10'd199,1'b0,10'd0},
    {2'd1,1'b1,1'b0,3'd0,10'd0,1'b0,10'd198},
    {2'd1,1'b1,1'b0,3'd0,10'd0,1'b1,10'd199},
    {2'd1,1'b1,1'b0,3'd0,10'd0,1'b1,10'd196},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b1,10'd197},
    {2'd0,1'b0,1'b1,3'b001,10'd198,1'b0,10'd0},
    {2'd0,1'b0,1'b0,3'b001,10'd198,1'b0,10'd0},
    {2'd1,1'b0,1'b0,3'd0,10'd0,1'b0,10'd198}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic upd(input logic [FW-1:0] f, input logic s, input logic [2:0] m);
    @(negedge clk);
    upd_en = 1'b1; upd_frame = f; upd_set = s; upd_mask = m;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic do_req(input logic e, output int fr, output bit wb, output bit err);
    int n = 0;
    fr = -1; wb = 0; err = 0;
    @(negedge clk);
    req = 1'b1; enh = e;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R10 busy after request", busy, 1);
    while (!gnt && !no_victim && n < 5000) begin
      if (wb_req) begin
        wb = 1;
        fr = wb_frame;
        @(negedge clk);
        chk(wb_req && !gnt && wb_frame == fr[FW-1:0], "R5 write-back held", wb_frame, fr);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        chk(gnt && gnt_frame == fr[FW-1:0], "R5 grant after ack", gnt_frame, fr);
      end else begin
        @(negedge clk);
        n++;
      end
    end
    if (n >= 5000) chk(0, "R10 request timeout", n, 0);
    err = no_victim;
    if (gnt) fr = gnt_frame;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int fr;
    bit wb, err;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !gnt && !wb_req && !no_victim, "R1 reset outputs", {busy, gnt, wb_req, no_victim}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][27:26] == 2'd0)
        upd(VEC[i][20:11], VEC[i][24], VEC[i][23:21]);
      else begin
        do_req(VEC[i][25], fr, wb, err);
        chk(fr == int'(VEC[i][9:0]) && !err, $sformatf("R2/R4/R6/R7/R9 vector %0d frame", i), fr, VEC[i][9:0]);
        chk(wb == VEC[i][10], $sformatf("R5/R6 vector %0d write-back", i), wb, VEC[i][10]);
      end
    end

    // R3 R8: all frames pinned
    for (int f = 193; f < 200; f++) upd(10'(f), 1'b1, 3'b100);
    do_req(1'b0, fr, wb, err);
    chk(err && fr == -1, "R8 simple all pinned", fr, -1);
    do_req(1'b1, fr, wb, err);
    chk(err && fr == -1, "R8 two-class all pinned", fr, -1);
    chk(!busy, "R8 idle after failure", busy, 0);

    // R3: only frame 196 unpinned
    upd(10'd196, 1'b0, 3'b100);
    do_req(1'b0, fr, wb, err);
    chk(fr == 196, "R3 only unpinned frame", fr, 196);

    // R1: init clears everything
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    chk(!busy && !gnt && !wb_req, "R1 after init", {busy, gnt, wb_req}, 0);
    do_req(1'b0, fr, wb, err);
    chk(fr == 192 && !wb, "R1 fill restarts at 192", fr, 192);
    // R2: pinned free frame skipped
    upd(10'd193, 1'b1, 3'b100);
    do_req(1'b0, fr, wb, err);
    chk(fr == 194 && !wb, "R2 pinned free frame skipped", fr, 194);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule